// File: doc/BRIEF.md
# Floating-Point State Initialization Controller

This block holds the architectural state of a stack-based floating-point unit: a control word, a status word, a tag word, an instruction pointer, a data pointer and the last-opcode register. It watches a stream of instruction bytes for the initialize instruction and recognises two forms. The non-waiting form is the byte pair DB E3. The waiting form is the byte 9B followed by DB E3. The waiting form runs as two separate steps. The first is a wait step on the 9B byte, which looks for pending unmasked exceptions. The second is the non-waiting initialize on the DB E3 pair.

Each step that completes is checked against three sideband inputs: a lock-prefix flag and two control bits, one for emulation and one for task switching. A step that passes without a fault may load the default state. A step that faults raises a one-cycle fault pulse that carries a code and the address of the faulting step, and it leaves every state register unchanged. A write port lets the surrounding logic, or a testbench, preload any state register.

The byte input is a valid/ready stream. A byte is consumed on every cycle in which both `in_valid` and `in_ready` are high. `in_ready` falls only while reset is asserted, so the block never pushes back in normal operation. A sender may hold `in_valid` low for any number of cycles between bytes. The sideband inputs are plain levels. They are sampled in the cycle that the completing byte of a step is accepted: the 9B byte for a wait step, or the E3 byte for an initialize step.

Top module: `fpu_init_ctrl`

## Requirements
- R1: Synchronous reset sets the registers to their defaults: control 16'h037F, status 0, tag 16'hFFFF, and instruction pointer, data pointer and opcode 0. `in_ready` is low while reset is high.
- R2: Accepting DB then E3 with no fault condition loads the same defaults as reset. The new values show at the outputs after the clock edge that accepts E3, and no fault pulse is raised.
- R3: A byte is consumed only when `in_valid` and `in_ready` are both high. A byte presented with `in_valid` low has no effect on decoding.
- R4: A 9B byte is a wait step. It raises fault code 3 (math fault) if, for some i in 0..5, status bit i is 1 and control bit i is 0. If it does not fault, the wait step changes no register.
- R5: The non-waiting initialize performs no pending-exception check. DB E3 still initializes while an unmasked exception is pending.
- R6: A step accepted with `lock_pfx` high raises fault code 1. This fault takes priority over all other faults.
- R7: A step accepted with `cr0_em` or `cr0_ts` high, and `lock_pfx` low, raises fault code 2. This fault takes priority over code 3.
- R8: A fault is a registered pulse on `fault_valid`, high for one cycle after the accepting edge, with `fault_code` non-zero (0 none, 1 lock, 2 unavailable, 3 math). A faulting step modifies no state register.
- R9: `fault_addr` carries the address of the faulting step: the 9B byte's `in_addr` for a wait step, and the DB byte's `in_addr` for an initialize step.
- R10: When `wr_en` is high, `wr_data` is written to the register chosen by `wr_sel` (0 control, 1 status, 2 tag, 3 instruction pointer, 4 data pointer, 5 opcode, taken from the low bits). Values 6 and 7 write nothing. An initialize in the same cycle takes precedence over the write.
- R11: A DB byte followed by any byte other than E3 abandons the pair, and that byte is decoded afresh. A second DB restarts the pair at its own address, and a 9B starts a wait step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte valid |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| in_byte | input | 8 | Instruction byte |
| in_addr | input | ADDR_W | Address of the instruction byte |
| lock_pfx | input | 1 | Lock prefix present on current instruction |
| cr0_em | input | 1 | Emulation control bit |
| cr0_ts | input | 1 | Task-switched control bit |
| wr_en | input | 1 | State register write enable |
| wr_sel | input | 3 | State register select |
| wr_data | input | ADDR_W | State register write data |
| ctrl_word | output | 16 | Control word |
| stat_word | output | 16 | Status word |
| tag_word | output | 16 | Tag word |
| ip_reg | output | ADDR_W | Last instruction pointer |
| dp_reg | output | ADDR_W | Last data pointer |
| opc_reg | output | OPC_W | Last opcode |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | Fault code |
| fault_addr | output | ADDR_W | Address of the faulting step |

## Verification
The assertions assume that reset is asserted before the first clock edge that matters. They also assume that the sideband levels are meaningful only in the cycle a step completes, and that a register write never coincides with a faulting step. The stimulus respects these assumptions. It changes the sideband and write inputs only while no byte is being presented, and it presents each step's bytes with `in_valid` pulsed for one cycle each. The sweep covers every combination of lock, emulation and task-switch bits, together with all 64 patterns of pending exception flags against a varying mask. It runs this set through both the waiting and the non-waiting form.

// File: rtl/fpu_init_pkg.sv
package fpu_init_pkg;
  localparam logic [15:0] CW_DEFAULT  = 16'h037F;
  localparam logic [15:0] SW_DEFAULT  = 16'h0000;
  localparam logic [15:0] TAG_DEFAULT = 16'hFFFF;

  localparam logic [7:0] BYTE_WAIT = 8'h9B;
  localparam logic [7:0] BYTE_ESC  = 8'hDB;
  localparam logic [7:0] BYTE_INIT = 8'hE3;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_LOCK = 2'd1,
    FLT_UNAV = 2'd2,
    FLT_MATH = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_STAT = 3'd1,
    SEL_TAG  = 3'd2,
    SEL_IP   = 3'd3,
    SEL_DP   = 3'd4,
    SEL_OPC  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/fpu_init_decode.sv
module fpu_init_decode
  import fpu_init_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [7:0]        byte_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              wait_step,
  output logic              init_step,
  output logic [ADDR_W-1:0] step_addr
);
  logic              esc_seen;
  logic [ADDR_W-1:0] esc_addr;
  logic              pair_done;

  assign pair_done = accept && esc_seen && (byte_in == BYTE_INIT);
  assign init_step = pair_done;
  // a non-E3 byte after DB is decoded as a fresh byte
  assign wait_step = accept && (byte_in == BYTE_WAIT);
  assign step_addr = init_step ? esc_addr : addr_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      esc_seen <= 1'b0;
      esc_addr <= '0;
    end else if (accept) begin
      if (byte_in == BYTE_ESC) begin
        esc_seen <= 1'b1;
        esc_addr <= addr_in;
      end else begin
        esc_seen <= 1'b0;
      end
    end
  end

  a_r11_one_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wait_step, init_step}));
  a_r9_pair_addr: assert property (@(posedge clk) disable iff (rst)
    (accept && byte_in == BYTE_ESC) |=> (!init_step || step_addr == $past(addr_in)));
endmodule

// File: rtl/fpu_init_check.sv
module fpu_init_check
  import fpu_init_pkg::*;
#(
  parameter int EXC_W = 6
) (
  input  logic             lock_pfx,
  input  logic             cr0_em,
  input  logic             cr0_ts,
  input  logic             check_pend,
  input  logic [EXC_W-1:0] exc_flags,
  input  logic [EXC_W-1:0] exc_masks,
  output fault_e           code
);
  logic [EXC_W-1:0] unmasked;
  logic             pending;

  for (genvar i = 0; i < EXC_W; i++) begin : g_pend
    assign unmasked[i] = exc_flags[i] & ~exc_masks[i];
  end
  assign pending = |unmasked;

  always_comb begin
    if (lock_pfx)                  code = FLT_LOCK;
    else if (cr0_em || cr0_ts)     code = FLT_UNAV;
    else if (check_pend && pending) code = FLT_MATH;
    else                           code = FLT_NONE;
  end

  always_comb begin
    a_r6_lock_first: assert (!lock_pfx || code == FLT_LOCK);
    a_r5_no_math_on_init: assert (check_pend || code != FLT_MATH);
  end
endmodule

// File: rtl/fpu_init_regs.sv
module fpu_init_regs
  import fpu_init_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OPC_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_init,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [15:0]       ctrl_word,
  output logic [15:0]       stat_word,
  output logic [15:0]       tag_word,
  output logic [ADDR_W-1:0] ip_reg,
  output logic [ADDR_W-1:0] dp_reg,
  output logic [OPC_W-1:0]  opc_reg
);
  always_ff @(posedge clk) begin
    if (rst || do_init) begin
      ctrl_word <= CW_DEFAULT;
      stat_word <= SW_DEFAULT;
      tag_word  <= TAG_DEFAULT;
      ip_reg    <= '0;
      dp_reg    <= '0;
      opc_reg   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: ctrl_word <= wr_data[15:0];
        SEL_STAT: stat_word <= wr_data[15:0];
        SEL_TAG:  tag_word  <= wr_data[15:0];
        SEL_IP:   ip_reg    <= wr_data;
        SEL_DP:   dp_reg    <= wr_data;
        SEL_OPC:  opc_reg   <= wr_data[OPC_W-1:0];
        default:  ;
      endcase
    end
  end

  a_r1_reset_defaults: assert property (@(posedge clk)
    rst |=> (ctrl_word == CW_DEFAULT && stat_word == '0 && tag_word == TAG_DEFAULT
             && ip_reg == '0 && dp_reg == '0 && opc_reg == '0));
  a_r2_init_defaults: assert property (@(posedge clk) disable iff (rst)
    do_init |=> (ctrl_word == CW_DEFAULT && stat_word == '0 && tag_word == TAG_DEFAULT
                 && ip_reg == '0 && dp_reg == '0 && opc_reg == '0));
  a_r10_bad_sel: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !do_init && wr_sel > 3'd5) |=>
      (ctrl_word == $past(ctrl_word) && stat_word == $past(stat_word)
       && tag_word == $past(tag_word) && ip_reg == $past(ip_reg)
       && dp_reg == $past(dp_reg) && opc_reg == $past(opc_reg)));
endmodule

// File: rtl/fpu_init_ctrl.sv
module fpu_init_ctrl
  import fpu_init_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OPC_W  = 11,
  parameter int EXC_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              lock_pfx,
  input  logic              cr0_em,
  input  logic              cr0_ts,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [15:0]       ctrl_word,
  output logic [15:0]       stat_word,
  output logic [15:0]       tag_word,
  output logic [ADDR_W-1:0] ip_reg,
  output logic [ADDR_W-1:0] dp_reg,
  output logic [OPC_W-1:0]  opc_reg,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic [ADDR_W-1:0] fault_addr
);
  logic              accept;
  logic              wait_step;
  logic              init_step;
  logic              any_step;
  logic [ADDR_W-1:0] step_addr;
  fault_e            step_code;
  logic              step_fault;
  logic              do_init;

  assign in_ready   = ~rst;
  assign accept     = in_valid && in_ready;
  assign any_step   = wait_step || init_step;
  assign step_fault = any_step && (step_code != FLT_NONE);
  assign do_init    = init_step && (step_code == FLT_NONE);

  fpu_init_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .byte_in   (in_byte),
    .addr_in   (in_addr),
    .wait_step (wait_step),
    .init_step (init_step),
    .step_addr (step_addr)
  );

  fpu_init_check #(.EXC_W(EXC_W)) u_check (
    .lock_pfx   (lock_pfx),
    .cr0_em     (cr0_em),
    .cr0_ts     (cr0_ts),
    .check_pend (wait_step),
    .exc_flags  (stat_word[EXC_W-1:0]),
    .exc_masks  (ctrl_word[EXC_W-1:0]),
    .code       (step_code)
  );

  fpu_init_regs #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .do_init   (do_init),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ctrl_word (ctrl_word),
    .stat_word (stat_word),
    .tag_word  (tag_word),
    .ip_reg    (ip_reg),
    .dp_reg    (dp_reg),
    .opc_reg   (opc_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
      fault_addr  <= '0;
    end else begin
      fault_valid <= step_fault;
      fault_code  <= step_fault ? step_code : FLT_NONE;
      if (step_fault) fault_addr <= step_addr;
    end
  end

  a_r8_code_nonzero: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> fault_code != FLT_NONE);
  a_r8_state_held: assert property (@(posedge clk) disable iff (rst)
    (step_fault && !wr_en) |=>
      (ctrl_word == $past(ctrl_word) && stat_word == $past(stat_word)
       && tag_word == $past(tag_word) && ip_reg == $past(ip_reg)
       && dp_reg == $past(dp_reg) && opc_reg == $past(opc_reg)));
  a_r6_lock_fault: assert property (@(posedge clk) disable iff (rst)
    (any_step && lock_pfx) |=> (fault_valid && fault_code == FLT_LOCK));
  a_r7_unav_fault: assert property (@(posedge clk) disable iff (rst)
    (any_step && !lock_pfx && (cr0_em || cr0_ts)) |=> (fault_valid && fault_code == FLT_UNAV));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !fault_valid);
endmodule

// File: tb/fpu_init_ctrl_bench.sv
module fpu_init_ctrl_bench;
  localparam int ADDR_W = 32;
  localparam int OPC_W  = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_byte = 8'h00;
  logic [ADDR_W-1:0] in_addr = '0;
  logic              lock_pfx = 1'b0, cr0_em = 1'b0, cr0_ts = 1'b0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_sel = 3'd0;
  logic [ADDR_W-1:0] wr_data = '0;
  logic [15:0]       ctrl_word, stat_word, tag_word;
  logic [ADDR_W-1:0] ip_reg, dp_reg, fault_addr;
  logic [OPC_W-1:0]  opc_reg;
  logic              fault_valid;
  logic [1:0]        fault_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] m_cw, m_sw, m_tw;
  logic [31:0] m_ip, m_dp;
  logic [10:0] m_op;

  always #10 clk = ~clk;

  fpu_init_ctrl u_fpu_init_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_addr(in_addr), .lock_pfx(lock_pfx),
    .cr0_em(cr0_em), .cr0_ts(cr0_ts), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_word(ctrl_word), .stat_word(stat_word),
    .tag_word(tag_word), .ip_reg(ip_reg), .dp_reg(dp_reg), .opc_reg(opc_reg),
    .fault_valid(fault_valid), .fault_code(fault_code), .fault_addr(fault_addr)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    chk(req, "ctrl", {48'd0, ctrl_word}, {48'd0, m_cw});
    chk(req, "stat", {48'd0, stat_word}, {48'd0, m_sw});
    chk(req, "tag",  {48'd0, tag_word},  {48'd0, m_tw});
    chk(req, "ip",   {32'd0, ip_reg},    {32'd0, m_ip});
    chk(req, "dp",   {32'd0, dp_reg},    {32'd0, m_dp});
    chk(req, "opc",  {53'd0, opc_reg},   {53'd0, m_op});
  endtask

  task automatic model_defaults();
    m_cw = 16'h037F; m_sw = 16'h0000; m_tw = 16'hFFFF;
    m_ip = '0; m_dp = '0; m_op = '0;
  endtask

  task automatic model_write(logic [2:0] s, logic [31:0] d);
    case (s)
      3'd0: m_cw = d[15:0];
      3'd1: m_sw = d[15:0];
      3'd2: m_tw = d[15:0];
      3'd3: m_ip = d;
      3'd4: m_dp = d;
      3'd5: m_op = d[10:0];
      default: ;
    endcase
  endtask

  task automatic write_reg(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(s, d);
  endtask

  task automatic send(logic [7:0] b, logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_fault(string req, logic [1:0] code, logic [31:0] a);
    chk(req, "fault_valid", {63'd0, fault_valid}, {63'd0, code != 2'd0});
    chk(req, "fault_code", {62'd0, fault_code}, {62'd0, code});
    if (code != 2'd0) chk(req, "fault_addr", {32'd0, fault_addr}, {32'd0, a});
  endtask

  task automatic preload(logic [5:0] st, logic [5:0] cm, logic [31:0] seed);
    write_reg(3'd0, {16'd0, 10'h00C, cm});
    write_reg(3'd1, {16'd0, 10'h0E0, st});
    write_reg(3'd2, seed ^ 32'h1234);
    write_reg(3'd3, seed + 32'hA000_0000);
    write_reg(3'd4, seed + 32'h5000_0000);
    write_reg(3'd5, seed ^ 32'h5A5);
  endtask

  task automatic run_case(bit wf, bit lk, bit em, bit ts, logic [5:0] st, logic [5:0] cm, logic [31:0] base);
    logic [1:0] ew, ei;
    bit pend;
    preload(st, cm, base);
    @(negedge clk);
    lock_pfx = lk; cr0_em = em; cr0_ts = ts;
    pend = (st & ~cm) != 6'd0;
    if (wf) begin
      ew = lk ? 2'd1 : (em || ts) ? 2'd2 : pend ? 2'd3 : 2'd0;
      send(8'h9B, base);
      chk_fault(lk ? "R6" : (em || ts) ? "R7" : "R4", ew, base);
      chk_regs("R8");
    end
    send(8'hDB, base + 1);
    chk_fault("R11", 2'd0, base);
    ei = lk ? 2'd1 : (em || ts) ? 2'd2 : 2'd0;
    send(8'hE3, base + 2);
    chk_fault(ei == 2'd0 ? (pend ? "R5" : "R2") : "R9", ei, base + 1);
    if (ei == 2'd0) model_defaults();
    chk_regs(ei == 2'd0 ? "R2" : "R8");
    @(negedge clk);
    chk("R8", "pulse_len", {63'd0, fault_valid}, 64'd0);
    lock_pfx = 0; cr0_em = 0; cr0_ts = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    model_defaults();
    @(negedge clk);
    chk("R1", "ready_in_reset", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_regs("R1");
    chk("R1", "ready", {63'd0, in_ready}, 64'd1);
    chk("R1", "fault_idle", {63'd0, fault_valid}, 64'd0);

    // R10 writes, ignored selects, init overriding write
    write_reg(3'd3, 32'hDEAD_BEEF);
    chk_regs("R10");
    write_reg(3'd6, 32'h1111_1111);
    chk_regs("R10");
    write_reg(3'd7, 32'h2222_2222);
    chk_regs("R10");
    send(8'hDB, 32'h100);
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'hE3; in_addr = 32'h101;
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'h0000_0041;
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
    model_defaults();
    chk_regs("R10");

    // R3: E3 with valid low is ignored; pair stays open
    write_reg(3'd4, 32'h0BAD_0000);
    send(8'hDB, 32'h200);
    @(negedge clk);
    in_byte = 8'hE3; in_addr = 32'h201;
    @(negedge clk);
    chk_regs("R3");
    in_valid = 1'b0;
    cr0_ts = 1'b1;
    send(8'hE3, 32'h202);
    chk_fault("R3", 2'd2, 32'h200);
    cr0_ts = 1'b0;

    // R11: DB DB E3 reports second DB address; DB x E3 aborts; DB 9B waits
    cr0_em = 1'b1;
    send(8'hDB, 32'h300);
    send(8'hDB, 32'h310);
    send(8'hE3, 32'h311);
    chk_fault("R11", 2'd2, 32'h310);
    send(8'hDB, 32'h320);
    send(8'h00, 32'h321);
    send(8'hE3, 32'h322);
    chk_fault("R11", 2'd0, 32'h0);
    send(8'hDB, 32'h330);
    send(8'h9B, 32'h340);
    chk_fault("R11", 2'd2, 32'h340);
    cr0_em = 1'b0;
    chk_regs("R11");

    // near-exhaustive sweep
    for (int f = 0; f < 2; f++)
      for (int sb = 0; sb < 8; sb++)
        for (int s = 0; s < 64; s++)
          run_case(f[0], sb[2], sb[1], sb[0], s[5:0], 6'((s * 37 + sb * 11) & 63),
                   32'h0010_0000 + 32'(f * 4096 + sb * 256 + s * 4));

    finish_run();
  end
endmodule